// File: doc/BRIEF.md
# Keypad Event Queue with Non-Destructive Peek

This block buffers keypad press and release events on their way to a host processor. Each event arrives already decoded, as a 7-bit key code plus a pressed flag. It is packed into one byte and appended to a 16-slot circular queue. The queue is tracked by a head pointer and a fill count.

The host has two ways to read the queue. A consuming read first moves the head forward by one slot and then returns the byte found there. As a result, the head slot always holds the event consumed most recently. A peek read takes a byte offset from the head and returns that slot without changing anything.

The queue raises a keypad interrupt request whenever an event is stored. If an event arrives while the queue is full, it is dropped, and an overflow error flag and an error-pending request are set. While both of those are set, every later event is discarded without further effect. A clear strobe empties the queue, and an acknowledge strobe drops the pending requests.

Top module: `key_event_queue`

## Requirements
- R1: A stored event byte holds the key code in bits 6:0. Bit 7 is 1 for a press and 0 for a release.
- R2: An accepted push writes slot (head + count) mod 16, increments `count` and sets `kp_irq`.
- R3: A push while `count` is 16 stores nothing and leaves `count` at 16. It sets both `ovf_err` and `err_pend`.
- R4: While `ovf_err` and `err_pend` are both 1, a push stores nothing and leaves `count` unchanged.
- R5: If `count` is 0 or 1, `pop_data` reads 0x00, and a consuming read leaves the queue unchanged.
- R6: If `count` is 2 or more, `pop_data` shows the slot at (head + 1) mod 16. On a consuming read the head advances by one (mod 16) and `count` decrements.
- R7: `peek_data` is the slot at (head + `peek_idx`) mod 16 when `peek_idx` < `count`, and 0x00 otherwise. A peek never changes the queue.
- R8: `clear` sets the head and `count` to zero and drops `kp_irq` and `err_pend`. It keeps `ovf_err`, and it overrides any push, pop or acknowledge in the same cycle.
- R9: When a consuming read and a push arrive in the same cycle, the read is applied first. So with a full queue both take effect and `count` stays 16.
- R10: A `push_stb` with `key_ok` low is ignored.
- R11: `irq_ack` drops `kp_irq` and `err_pend` but keeps `ovf_err`. A flag set by a push in the same cycle wins over the acknowledge.
- R12: After reset, `count` is 0, all flags are 0, and both data outputs read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Empty the queue and drop pending requests |
| push_stb | input | 1 | Push strobe |
| key_ok | input | 1 | Qualifies the push strobe with a valid key |
| key_code | input | 7 | Decoded key code |
| key_pressed | input | 1 | 1 = press, 0 = release |
| pop_stb | input | 1 | Consuming read strobe |
| pop_data | output | 8 | Byte returned by a consuming read in this cycle |
| peek_idx | input | 8 | Byte offset from the head for a peek |
| peek_data | output | 8 | Peeked byte |
| irq_ack | input | 1 | Acknowledge of the pending requests |
| count | output | 5 | Number of occupied slots, 0 to 16 |
| kp_irq | output | 1 | Keypad event request |
| err_pend | output | 1 | Error-pending request |
| ovf_err | output | 1 | Sticky overflow error flag |

## Verification
The properties assume that every strobe is sampled once per clock edge. They also assume that `push_stb` and `key_ok` together mean a single event, and that `clear` overrides everything in its cycle, so each property excludes the cycles in which `clear` is high. The stimulus changes inputs one time unit after the rising edge and holds every strobe for exactly one cycle. It drives combined pop and push cycles only where the pop-first ordering is the behaviour under test. The peek index ranges over values below, at and above the count, including offsets that wrap past slot 15.

// File: rtl/keyq_pkg.sv
package keyq_pkg;

    localparam int KEY_W  = 7;
    localparam int BYTE_W = KEY_W + 1;

    typedef logic [BYTE_W-1:0] evt_byte_t;

    // press flag sits above the key code
    function automatic evt_byte_t pack_event(input logic [KEY_W-1:0] code,
                                             input logic pressed);
        return {pressed, code};
    endfunction

endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [PTR_W-1:0]  rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_addr == PTR_W'(g)))
                slot_d = wr_data;
        end
        always_ff @(posedge clk) begin
            slot_q[g] <= slot_d;
        end
    end

    always_comb begin
        rd_a_data = slot_q[rd_a_addr];
        rd_b_data = slot_q[rd_b_addr];
    end

endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl #(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             irq_ack,
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] fill,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             kp_irq,
    output logic             err_pend,
    output logic             ovf_err
);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [CNT_W-1:0] fill;
        logic             kp;
        logic             errp;
        logic             ovf;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  blocked;

    assign blocked = st_q.ovf && st_q.errp;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        if (clear) begin
            st_d.head = '0;
            st_d.fill = '0;
            st_d.kp   = 1'b0;
            st_d.errp = 1'b0;
        end else begin
            if (irq_ack) begin
                st_d.kp   = 1'b0;
                st_d.errp = 1'b0;
            end
            // consuming read is applied ahead of the push
            if (pop_req && (st_q.fill >= CNT_W'(2))) begin
                st_d.head = st_q.head + PTR_W'(1);
                st_d.fill = st_q.fill - CNT_W'(1);
            end
            if (push_req && !blocked) begin
                if (st_d.fill == CNT_W'(DEPTH)) begin
                    st_d.ovf  = 1'b1;
                    st_d.errp = 1'b1;
                end else begin
                    wr_en     = 1'b1;
                    wr_addr   = st_d.head + st_d.fill[PTR_W-1:0];
                    st_d.fill = st_d.fill + CNT_W'(1);
                    st_d.kp   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head     = st_q.head;
    assign fill     = st_q.fill;
    assign kp_irq   = st_q.kp;
    assign err_pend = st_q.errp;
    assign ovf_err  = st_q.ovf;

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    assert_push_sets_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !(ovf_err && err_pend) && !pop_req && !clear &&
         fill < CNT_W'(DEPTH)) |=> (kp_irq && fill == $past(fill) + CNT_W'(1)));

    assert_full_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !(ovf_err && err_pend) && !pop_req && !clear &&
         fill == CNT_W'(DEPTH)) |=> (ovf_err && err_pend && fill == CNT_W'(DEPTH)));

    assert_blocked_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && ovf_err && err_pend && !pop_req && !clear) |=> $stable(fill));

    assert_short_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fill <= CNT_W'(1) && !push_req && !clear)
        |=> ($stable(head) && $stable(fill)));

    assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fill >= CNT_W'(2) && !push_req && !clear)
        |=> (fill == $past(fill) - CNT_W'(1) && head == $past(head) + PTR_W'(1)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0 && head == '0 && !kp_irq && !err_pend));

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      push_stb,
    input  logic                      key_ok,
    input  logic [keyq_pkg::KEY_W-1:0] key_code,
    input  logic                      key_pressed,
    input  logic                      pop_stb,
    output logic [keyq_pkg::BYTE_W-1:0] pop_data,
    input  logic [IDX_W-1:0]          peek_idx,
    output logic [keyq_pkg::BYTE_W-1:0] peek_data,
    input  logic                      irq_ack,
    output logic [CNT_W-1:0]          count,
    output logic                      kp_irq,
    output logic                      err_pend,
    output logic                      ovf_err
);
    import keyq_pkg::*;

    logic [PTR_W-1:0] head;
    logic [CNT_W-1:0] fill;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] pop_addr, peek_addr;
    evt_byte_t        pop_raw, peek_raw;
    logic             push_req;
    logic             peek_hit;

    assign push_req = push_stb && key_ok;

    keyq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .push_req (push_req),
        .pop_req  (pop_stb),
        .irq_ack  (irq_ack),
        .head     (head),
        .fill     (fill),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .kp_irq   (kp_irq),
        .err_pend (err_pend),
        .ovf_err  (ovf_err)
    );

    assign pop_addr  = head + PTR_W'(1);
    assign peek_addr = head + peek_idx[PTR_W-1:0];

    keyq_store #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) store_i (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (pack_event(key_code, key_pressed)),
        .rd_a_addr (pop_addr),
        .rd_a_data (pop_raw),
        .rd_b_addr (peek_addr),
        .rd_b_data (peek_raw)
    );

    always_comb begin
        peek_hit  = (32'(peek_idx) < 32'(fill));
        pop_data  = (fill >= CNT_W'(2)) ? pop_raw : '0;
        peek_data = peek_hit ? peek_raw : '0;
        count     = fill;
    end

    assert_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= CNT_W'(1)) |-> (pop_data == '0));

    assert_peek_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(peek_idx) >= 32'(count)) |-> (peek_data == '0));

endmodule

// File: tb/key_event_queue_tb.sv
module key_event_queue_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0, push_stb = 1'b0, key_ok = 1'b0, key_pressed = 1'b0;
    logic [6:0] key_code = '0;
    logic       pop_stb = 1'b0, irq_ack = 1'b0;
    logic [7:0] peek_idx = '0;
    logic [7:0] pop_data, peek_data;
    logic [4:0] count;
    logic       kp_irq, err_pend, ovf_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_event_queue dut_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push_stb(push_stb),
        .key_ok(key_ok), .key_code(key_code), .key_pressed(key_pressed),
        .pop_stb(pop_stb), .pop_data(pop_data), .peek_idx(peek_idx),
        .peek_data(peek_data), .irq_ack(irq_ack), .count(count),
        .kp_irq(kp_irq), .err_pend(err_pend), .ovf_err(ovf_err)
    );

    typedef struct packed {
        logic       push;
        logic       pressed;
        logic [6:0] code;
        logic       pop;
        logic [7:0] exp_pop;
        logic [4:0] exp_cnt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 7'h10, 1'b0, 8'h00, 5'd1},
        '{1'b1, 1'b0, 7'h25, 1'b0, 8'h00, 5'd2},
        '{1'b0, 1'b0, 7'h00, 1'b1, 8'h25, 5'd1},
        '{1'b0, 1'b0, 7'h00, 1'b1, 8'h00, 5'd1},
        '{1'b1, 1'b1, 7'h3c, 1'b0, 8'h00, 5'd2},
        '{1'b1, 1'b0, 7'h01, 1'b0, 8'hbc, 5'd3},
        '{1'b1, 1'b1, 7'h7f, 1'b1, 8'hbc, 5'd3},
        '{1'b0, 1'b0, 7'h00, 1'b1, 8'h01, 5'd2},
        '{1'b0, 1'b0, 7'h00, 1'b1, 8'hff, 5'd1},
        '{1'b0, 1'b0, 7'h00, 1'b1, 8'h00, 5'd1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // inputs are applied 1 unit after a rising edge; one edge then passes
    task automatic tick();
        @(posedge clk);
        #1;
        clear = 0; push_stb = 0; key_ok = 0; pop_stb = 0; irq_ack = 0;
    endtask

    task automatic push_ev(input logic [6:0] c, input logic p);
        push_stb = 1; key_ok = 1; key_code = c; key_pressed = p;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 count", count, 0);
        chk("R12 flags", {kp_irq, err_pend, ovf_err}, 0);
        chk("R12 pop_data", pop_data, 0);
        chk("R12 peek_data", peek_data, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // vector walk: R2 count growth, R5/R6 consuming reads, R9 pop then push
        for (int i = 0; i < NV; i++) begin
            push_stb = VECS[i].push; key_ok = VECS[i].push;
            key_code = VECS[i].code; key_pressed = VECS[i].pressed;
            pop_stb = VECS[i].pop;
            #1;
            chk("R6 R5 pop_data", pop_data, VECS[i].exp_pop);
            tick();
            chk("R2 R9 count", count, VECS[i].exp_cnt);
        end

        // head is slot 4 holding 0xff, count 1
        peek_idx = 8'd0; #1;
        chk("R7 R1 peek head", peek_data, 8'hff);
        peek_idx = 8'd1; #1;
        chk("R7 peek beyond count", peek_data, 8'h00);
        peek_idx = 8'd200; #1;
        chk("R7 peek large index", peek_data, 8'h00);
        chk("R7 peek no change", count, 1);
        chk("R2 kp_irq set", kp_irq, 1);

        irq_ack = 1; tick();
        chk("R11 ack drops kp_irq", kp_irq, 0);

        push_stb = 1; key_ok = 0; key_code = 7'h22; key_pressed = 1; tick();
        chk("R10 no-key push count", count, 1);
        chk("R10 no-key push irq", kp_irq, 0);

        clear = 1; push_stb = 1; key_ok = 1; key_code = 7'h05; tick();
        chk("R8 clear count", count, 0);
        chk("R8 clear beats push irq", kp_irq, 0);
        peek_idx = 8'd0; #1;
        chk("R8 peek after clear", peek_data, 0);

        // build a wrapped full queue
        push_ev(7'h40, 1'b1);
        push_ev(7'h41, 1'b0);
        pop_stb = 1; #1;
        chk("R6 pop second event", pop_data, 8'h41);
        tick();
        for (int j = 0; j < 15; j++) push_ev(7'(8'h50 + j), j[0]);
        chk("R2 full count", count, 16);
        peek_idx = 8'd0; #1;
        chk("R7 peek head after pop", peek_data, 8'h41);
        for (int k = 1; k < 16; k++) begin
            peek_idx = 8'(k); #1;
            chk("R7 R1 wrapped peek", peek_data, {1'(k - 1), 7'(8'h50 + k - 1)});
        end
        peek_idx = 8'd16; #1;
        chk("R7 peek at count", peek_data, 0);

        push_ev(7'h66, 1'b1);
        chk("R3 overflow count", count, 16);
        chk("R3 overflow flags", {ovf_err, err_pend}, 2'b11);
        peek_idx = 8'd0; #1;
        chk("R3 head slot kept", peek_data, 8'h41);

        push_ev(7'h67, 1'b1);
        chk("R4 blocked count", count, 16);
        peek_idx = 8'd0; #1;
        chk("R4 blocked no store", peek_data, 8'h41);

        irq_ack = 1; tick();
        chk("R11 ack err_pend", err_pend, 0);
        chk("R11 ovf kept", ovf_err, 1);

        pop_stb = 1; push_stb = 1; key_ok = 1; key_code = 7'h2a; key_pressed = 1; #1;
        chk("R9 pop data at full", pop_data, 8'h50);
        tick();
        chk("R9 count stays full", count, 16);
        peek_idx = 8'd15; #1;
        chk("R9 push after pop", peek_data, 8'haa);
        peek_idx = 8'd0; #1;
        chk("R6 new head", peek_data, 8'h50);

        irq_ack = 1; push_stb = 1; key_ok = 1; pop_stb = 1; key_code = 7'h03; key_pressed = 0; tick();
        chk("R11 push beats ack", kp_irq, 1);

        clear = 1; tick();
        chk("R8 clear keeps ovf", ovf_err, 1);
        chk("R8 clear drops err_pend", err_pend, 0);
        chk("R8 clear empties", count, 0);

        pop_stb = 1; #1;
        chk("R5 pop empty data", pop_data, 0);
        tick();
        chk("R5 pop empty count", count, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule